// File: doc/BRIEF.md
# Streaming SEC-DED Block Code Engine for Flash Pages

The engine builds a Hamming check code with single-error correction and double-error detection over one fixed-size block of flash data (512 bytes by default), receiving one byte per clock. A calculation starts only when an access begins at an address aligned to the block size. The block ends when its final byte arrives. It can also end earlier, on the byte that carries the last-transfer flag, and in that case every byte not delivered counts as zero. For a write, the finished check code is presented for one cycle so that it can be stored in the page's spare area. For a read, the engine then waits for the stored check code, compares the two and reports one of four results. The results are: clean, a single flipped data bit (with its byte offset and bit index), a single flipped bit in the stored code, or an uncorrectable error.

The control is a five-state machine. `ST_IDLE` goes to `ST_ACCUM` on an aligned start. `ST_ACCUM` goes to `ST_FINISH` on the final or flagged byte. `ST_FINISH` goes to `ST_WAIT_CHK` for a read and back to `ST_IDLE` for a write. `ST_WAIT_CHK` goes to `ST_REPORT` when the stored code arrives. `ST_REPORT` always returns to `ST_IDLE`. Every state other than `ST_IDLE` holds `busy` high.

Top module: `hamming_page_ecc`

## Requirements
- R1: After reset, `busy`, `done` and `res_vld` are all low.
- R2: A start is taken only in idle and only when the low log2(BLK_BYTES) address bits are zero. An unaligned start leaves `busy` low, and any bytes sent afterwards have no effect on the next block's code.
- R3: Data bit j of byte offset a has position p = 8*a + j (12 bits by default). `code_out[i]` (i = 0..11) is the XOR of all data bits whose bit i of p is 0. `code_out[12+i]` is the XOR of all data bits whose bit i of p is 1.
- R4: A block with no last flag ends on its BLK_BYTES-th accepted byte. `done` is high in the cycle after that byte is accepted.
- R5: A byte accepted with `byte_last` high ends the block, and the bytes not delivered count as zero. `done` follows one cycle later.
- R6: `done` is a one-cycle pulse, and `code_out` stays valid from that pulse until the next start. After a write the engine is idle again in the cycle that follows `done`.
- R7: After a read block, the engine waits for `chk_vld`. In the cycle after `chk_vld` is sampled, `res_vld` is high for one cycle.
- R8: Let the syndrome be the stored code XOR the computed code. When the syndrome is zero, `res_status` is 0 (clean).
- R9: When exactly 12 syndrome bits are set and the upper half is the bitwise complement of the lower half, `res_status` is 1. In that case `err_byte` is syndrome bits 23:15 and `err_bit` is bits 14:12. For every other status, both fields are zero.
- R10: When exactly one syndrome bit is set, `res_status` is 2 (the error is in the stored code).
- R11: Any other nonzero syndrome, including every double-bit data error, gives `res_status` 3 (uncorrectable).
- R12: A byte presented while `byte_vld` is low is ignored, so gaps in the stream do not change the code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_start | input | 1 | Access begins this cycle |
| acc_addr | input | ADDR_W | Start address of the access |
| acc_read | input | 1 | 1 = read access, 0 = write access |
| byte_vld | input | 1 | Data byte valid |
| byte_data | input | 8 | Data byte |
| byte_last | input | 1 | Final byte of the transfer |
| chk_vld | input | 1 | Stored check code valid (read only) |
| chk_code | input | CODE_W | Stored check code read from the spare area |
| busy | output | 1 | Engine not idle |
| done | output | 1 | Block finished; `code_out` valid |
| code_out | output | CODE_W | Computed check code |
| res_vld | output | 1 | Read result valid |
| res_status | output | 2 | 0 clean, 1 data bit fixed, 2 code bit, 3 uncorrectable |
| err_byte | output | OFS_W | Byte offset of a correctable data error |
| err_bit | output | 3 | Bit index of a correctable data error |

## Verification
The assertions assume that `chk_vld` is raised only while the engine is waiting after a read. They also assume that bytes arrive only between an accepted start and the end of the block, so that each result pulse traces back to a stored code sampled one cycle earlier. The stimulus follows these rules: it sends the stored code only after the cycle in which `done` appears, and it sends a new start only from idle. The one exception is the unaligned-start case, where bytes are sent on purpose while the engine is idle to show that they are dropped.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACCUM,
        ST_FINISH,
        ST_WAIT_CHK,
        ST_REPORT
    } ecc_state_t;

    typedef enum logic [1:0] {
        RES_CLEAN    = 2'd0,
        RES_DATA_FIX = 2'd1,
        RES_CODE_FIX = 2'd2,
        RES_UNCORR   = 2'd3
    } ecc_res_t;

    // Mask of the bit lanes inside a byte whose lane index has bit k set.
    function automatic logic [7:0] lane_mask(input int k);
        logic [7:0] m;
        for (int j = 0; j < 8; j++) begin
            m[j] = ((j >> k) & 1) != 0;
        end
        return m;
    endfunction

endpackage

// File: rtl/ecc_blk_ctr.sv
module ecc_blk_ctr #(
    parameter int BLK_BYTES = 512,
    localparam int OFS_W = $clog2(BLK_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [OFS_W-1:0] cnt,
    output logic             at_end
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_end = (cnt == OFS_W'(BLK_BYTES - 1));

endmodule

// File: rtl/ecc_byte_acc.sv
module ecc_byte_acc
    import ecc_pkg::*;
#(
    parameter int OFS_W = 9,
    localparam int POS_W = OFS_W + 3,
    localparam int CODE_W = 2 * POS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [7:0]        data,
    output logic [CODE_W-1:0] code
);

    logic [POS_W-1:0] even_q, odd_q;
    logic [POS_W-1:0] even_d, odd_d;
    logic             byte_par;

    assign byte_par = ^data;

    // Positions 0..2: the bit index inside the byte.
    for (genvar k = 0; k < 3; k++) begin : g_lane
        localparam logic [7:0] HI = lane_mask(k);
        assign odd_d[k]  = odd_q[k]  ^ (^(data & HI));
        assign even_d[k] = even_q[k] ^ (^(data & ~HI));
    end

    // Positions 3 and up: one byte-offset bit each.
    for (genvar k = 0; k < OFS_W; k++) begin : g_ofs
        assign odd_d[3+k]  = odd_q[3+k]  ^ (byte_par &  ofs[k]);
        assign even_d[3+k] = even_q[3+k] ^ (byte_par & ~ofs[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            even_q <= '0;
            odd_q  <= '0;
        end else if (clr) begin
            even_q <= '0;
            odd_q  <= '0;
        end else if (en) begin
            even_q <= even_d;
            odd_q  <= odd_d;
        end
    end

    assign code = {odd_q, even_q};

endmodule

// File: rtl/ecc_syn_decode.sv
module ecc_syn_decode
    import ecc_pkg::*;
#(
    parameter int OFS_W = 9,
    localparam int POS_W = OFS_W + 3,
    localparam int CODE_W = 2 * POS_W
) (
    input  logic [CODE_W-1:0] stored,
    input  logic [CODE_W-1:0] computed,
    output logic [1:0]        status,
    output logic [OFS_W-1:0]  err_byte,
    output logic [2:0]        err_bit
);

    logic [CODE_W-1:0] syn;
    logic [POS_W-1:0]  syn_lo, syn_hi;
    int unsigned       ones;

    assign syn    = stored ^ computed;
    assign syn_lo = syn[POS_W-1:0];
    assign syn_hi = syn[CODE_W-1:POS_W];
    assign ones   = $countones(syn);

    always_comb begin
        status   = RES_UNCORR;
        err_byte = '0;
        err_bit  = '0;
        if (syn == '0) begin
            status = RES_CLEAN;
        end else if (ones == POS_W && (syn_hi ^ syn_lo) == '1) begin
            status   = RES_DATA_FIX;
            err_byte = syn_hi[POS_W-1:3];
            err_bit  = syn_hi[2:0];
        end else if (ones == 1) begin
            status = RES_CODE_FIX;
        end
    end

endmodule

// File: rtl/hamming_page_ecc.sv
module hamming_page_ecc
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BLK_BYTES = 512,
    localparam int OFS_W = $clog2(BLK_BYTES),
    localparam int CODE_W = 2 * (OFS_W + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_start,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_read,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              byte_last,
    input  logic              chk_vld,
    input  logic [CODE_W-1:0] chk_code,
    output logic              busy,
    output logic              done,
    output logic [CODE_W-1:0] code_out,
    output logic              res_vld,
    output logic [1:0]        res_status,
    output logic [OFS_W-1:0]  err_byte,
    output logic [2:0]        err_bit
);

    ecc_state_t       state, state_nx;
    logic             rd_q;
    logic             aligned, accept, take, final_byte;
    logic [OFS_W-1:0] cnt;
    logic             at_end;
    logic [1:0]       dec_status;
    logic [OFS_W-1:0] dec_byte;
    logic [2:0]       dec_bit;
    logic [1:0]       status_q;
    logic [OFS_W-1:0] byte_q;
    logic [2:0]       bit_q;

    assign aligned    = (acc_addr[OFS_W-1:0] == '0);
    assign accept     = (state == ST_IDLE) && acc_start && aligned;
    assign take       = (state == ST_ACCUM) && byte_vld;
    assign final_byte = take && (byte_last || at_end);

    ecc_blk_ctr #(.BLK_BYTES(BLK_BYTES)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (accept),
        .inc    (take),
        .cnt    (cnt),
        .at_end (at_end)
    );

    ecc_byte_acc #(.OFS_W(OFS_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .en    (take),
        .ofs   (cnt),
        .data  (byte_data),
        .code  (code_out)
    );

    ecc_syn_decode #(.OFS_W(OFS_W)) u_dec (
        .stored   (chk_code),
        .computed (code_out),
        .status   (dec_status),
        .err_byte (dec_byte),
        .err_bit  (dec_bit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (accept)     state_nx = ST_ACCUM;
            ST_ACCUM:    if (final_byte) state_nx = ST_FINISH;
            ST_FINISH:   state_nx = rd_q ? ST_WAIT_CHK : ST_IDLE;
            ST_WAIT_CHK: if (chk_vld)    state_nx = ST_REPORT;
            ST_REPORT:   state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // Direction latch and result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q     <= 1'b0;
            status_q <= RES_CLEAN;
            byte_q   <= '0;
            bit_q    <= '0;
        end else begin
            if (accept) begin
                rd_q <= acc_read;
            end
            if (state == ST_WAIT_CHK && chk_vld) begin
                status_q <= dec_status;
                byte_q   <= dec_byte;
                bit_q    <= dec_bit;
            end
        end
    end

    // Outputs
    always_comb begin
        busy       = (state != ST_IDLE);
        done       = (state == ST_FINISH);
        res_vld    = (state == ST_REPORT);
        res_status = status_q;
        err_byte   = byte_q;
        err_bit    = bit_q;
    end

    a_r2_unaligned_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && acc_start && !aligned) |=> (state == ST_IDLE));

    a_r4_end_at_block: assert property (@(posedge clk) disable iff (!rst_n)
        (take && at_end) |=> done);

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(code_out));

    a_r7_res_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $past(chk_vld));

    a_r9_fields_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_status != 2'd1) |-> (err_byte == '0 && err_bit == '0));

endmodule

// File: tb/tb_hamming_page_ecc.sv
module tb_hamming_page_ecc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_start = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_read = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        byte_last = 1'b0;
    logic        chk_vld = 1'b0;
    logic [23:0] chk_code = '0;
    logic        busy, done, res_vld;
    logic [23:0] code_out;
    logic [1:0]  res_status;
    logic [8:0]  err_byte;
    logic [2:0]  err_bit;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_en = 1'b0;

    always #2.5 clk = ~clk;

    hamming_page_ecc dut (
        .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .acc_addr(acc_addr),
        .acc_read(acc_read), .byte_vld(byte_vld), .byte_data(byte_data),
        .byte_last(byte_last), .chk_vld(chk_vld), .chk_code(chk_code),
        .busy(busy), .done(done), .code_out(code_out), .res_vld(res_vld),
        .res_status(res_status), .err_byte(err_byte), .err_bit(err_bit)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] calc_code(input logic [7:0] arr [512]);
        logic [23:0] c = '0;
        for (int p = 0; p < 4096; p++) begin
            if (arr[p / 8][p % 8]) begin
                for (int i = 0; i < 12; i++) begin
                    if (((p >> i) & 1) != 0) c[12 + i] = ~c[12 + i];
                    else                     c[i]      = ~c[i];
                end
            end
        end
        return c;
    endfunction

    task automatic decode(input logic [23:0] s, output int st, output int eb, output int eb2);
        int ones = 0;
        for (int i = 0; i < 24; i++) ones += int'(s[i]);
        eb = 0; eb2 = 0;
        if (ones == 0) st = 0;
        else if (ones == 12 && (s[23:12] ^ s[11:0]) == 12'hFFF) begin
            st = 1; eb = int'(s[23:15]); eb2 = int'(s[14:12]);
        end else if (ones == 1) st = 2;
        else st = 3;
    endtask

    // Behavioural reference model: 0 idle, 1 collecting, 2 done, 3 waiting, 4 result
    int          m_phase = 0;
    int          m_cnt = 0;
    bit          m_rd = 0;
    logic [7:0]  m_mem [512];
    logic [23:0] m_code = '0;
    int          m_st = 0, m_eb = 0, m_ebit = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0;
            m_cnt = 0;
        end else begin
            case (m_phase)
                0: if (acc_start && acc_addr[8:0] == 9'd0) begin
                       m_phase = 1; m_cnt = 0; m_rd = acc_read;
                       for (int i = 0; i < 512; i++) m_mem[i] = 8'h00;
                   end
                1: if (byte_vld) begin
                       m_mem[m_cnt] = byte_data;
                       m_cnt++;
                       if (byte_last || m_cnt == 512) begin
                           m_code = calc_code(m_mem);
                           m_phase = 2;
                       end
                   end
                2: m_phase = m_rd ? 3 : 0;
                3: if (chk_vld) begin
                       decode(chk_code ^ m_code, m_st, m_eb, m_ebit);
                       m_phase = 4;
                   end
                default: m_phase = 0;
            endcase
        end
    end

    string st_tag;
    always @(negedge clk) begin
        if (cmp_en) begin
            check(busy == (m_phase != 0), "R2 busy", int'(busy), int'(m_phase != 0));
            check(done == (m_phase == 2), "R6 done", int'(done), int'(m_phase == 2));
            if (m_phase == 2)
                check(code_out == m_code, "R3 code_out", int'(code_out), int'(m_code));
            check(res_vld == (m_phase == 4), "R7 res_vld", int'(res_vld), int'(m_phase == 4));
            if (m_phase == 4) begin
                case (m_st)
                    0: st_tag = "R8";
                    1: st_tag = "R9";
                    2: st_tag = "R10";
                    default: st_tag = "R11";
                endcase
                check(int'(res_status) == m_st, {st_tag, " status"}, int'(res_status), m_st);
                check(int'(err_byte) == m_eb, "R9 err_byte", int'(err_byte), m_eb);
                check(int'(err_bit) == m_ebit, "R9 err_bit", int'(err_bit), m_ebit);
            end
        end
    end

    logic [7:0] stim [512];

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 512; i++) stim[i] = 8'((i * 37 + seed * 11) ^ (i >> 3) ^ seed);
    endtask

    task automatic start(input logic [31:0] a, input bit rd);
        acc_start = 1'b1; acc_addr = a; acc_read = rd;
        tick();
        acc_start = 1'b0;
    endtask

    task automatic send(input int n, input bit use_last, input bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 3) == 1) begin
                byte_vld = 1'b0; byte_data = 8'hA5;
                tick();
            end
            byte_vld = 1'b1; byte_data = stim[i];
            byte_last = use_last && (i == n - 1);
            tick();
        end
        byte_vld = 1'b0; byte_last = 1'b0;
    endtask

    task automatic read_block(input int n, input bit use_last, input logic [23:0] stored);
        start(32'h0000_0400, 1'b1);
        send(n, use_last, 1'b0);
        tick();
        chk_vld = 1'b1; chk_code = stored;
        tick();
        chk_vld = 1'b0;
        tick();
        tick();
    endtask

    task automatic fix_case(input int ob, input int bb, input int seed);
        logic [23:0] stored;
        fill(seed);
        stored = calc_code(stim);
        stim[ob][bb] = ~stim[ob][bb];
        start(32'h0000_0600, 1'b1);
        send(512, 1'b0, 1'b0);
        tick();
        chk_vld = 1'b1; chk_code = stored;
        tick();
        chk_vld = 1'b0;
        #1;
        check(res_vld && res_status == 2'd1, "R9 status", int'(res_status), 1);
        check(int'(err_byte) == ob && int'(err_bit) == bb, "R9 location",
              int'({err_byte, err_bit}), ob * 8 + bb);
        tick();
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [23:0] c;
        for (int i = 0; i < 4; i++) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!busy && !done && !res_vld, "R1 reset", int'({busy, done, res_vld}), 0);
        cmp_en = 1'b1;
        tick();

        // R3 R4: full write block
        fill(1);
        start(32'h0001_0000, 1'b0);
        send(512, 1'b0, 1'b0);
        tick(); tick();

        // R5: early end on last flag
        fill(2);
        start(32'h0001_0200, 1'b0);
        send(100, 1'b1, 1'b0);
        tick(); tick();

        // R12: stream with gaps
        fill(3);
        start(32'h0001_0400, 1'b0);
        send(512, 1'b0, 1'b1);
        tick(); tick();

        // R2: unaligned start, bytes must be dropped
        fill(4);
        start(32'h0000_0204, 1'b0);
        send(20, 1'b1, 1'b0);
        tick();
        fill(5);
        start(32'h0000_0000, 1'b0);
        send(64, 1'b1, 1'b0);
        tick(); tick();

        // R8: clean read
        fill(6);
        read_block(512, 1'b0, calc_code(stim));

        // R5 R8: short read with last flag
        fill(7);
        read_block(200, 1'b1, calc_code(stim));

        // R9: single data bit errors at corners and middle
        fix_case(0, 0, 8);
        fix_case(511, 7, 9);
        fix_case(257, 3, 10);

        // R10: single bit flipped in the stored code
        fill(11);
        c = calc_code(stim);
        read_block(512, 1'b0, c ^ 24'h00_0010);
        fill(11);
        read_block(512, 1'b0, c ^ 24'h80_0000);

        // R11: double data bit error
        fill(12);
        c = calc_code(stim);
        stim[5][1] = ~stim[5][1];
        stim[300][6] = ~stim[300][6];
        read_block(512, 1'b0, c);

        // R11: two flipped stored-code bits
        fill(13);
        read_block(512, 1'b0, calc_code(stim) ^ 24'h00_0101);

        tick(); tick();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule